// File: doc/BRIEF.md
# Line-Frequency Tick Counter

This block is a real-time clock peripheral for a processor's I/O bus. An external source delivers one strobe per cycle of the mains supply, at 50 or 60 per second; those are the only two supported rates. While counting is switched on, every strobe advances an 18-bit count word by one. When the count rolls over from all ones to zero, a sticky completion flag is raised. Software can preset the count through a load port, for example to the two's complement of an interval, so that the flag marks the end of that interval.

The processor talks to the block through a command strobe carrying a 6-bit pulse field. One bit asks for a skip when the flag is set. Another bit clears the flag and, in the same action, switches counting on or off according to a modifier bit. A separate clear-all-flags input, shared with the other peripherals, drops the flag but leaves counting as it was. The flag is also presented as a plain status bit for the shared I/O status word.

All inputs are synchronous to `clk`. The tick is a one-cycle strobe that has already been brought into this clock domain. No input or output has back-pressure: a command, tick or load that is presented is always taken in that cycle.

Top module: `ltc_line_clock`

## Requirements
- R1: While `rst_n` is low, `count_q` is 0, `clk_flag` is 0 and `counting` is 0.
- R2: A `tick` with `counting` high adds one to `count_q` at the next edge, modulo 2^18. A `tick` with `counting` low leaves `count_q` unchanged.
- R3: A counting tick that takes `count_q` from 0x3FFFF to 0 sets `clk_flag` at the same edge.
- R4: `clk_flag` is never set by a counting tick that lands on a nonzero value. Once set, it stays set until a clear.
- R5: `skip` is high in the same cycle exactly when `cmd_valid` is high, `cmd_pulse` bit 0 is 1, and `clk_flag` is 1. `skip` uses the flag value from before any clear in that command.
- R6: A command with `cmd_pulse` bit 2 set clears `clk_flag`. If bit 5 is also set, `counting` becomes 1; if bit 5 is clear, `counting` becomes 0.
- R7: `cmd_pulse` has no effect while `cmd_valid` is low. Bit 5 has no effect without bit 2.
- R8: `clear_all` clears `clk_flag` and leaves `counting` unchanged.
- R9: When a flag clear (a bit-2 command or `clear_all`) and a wrapping tick occur in the same cycle, `clk_flag` ends up 0. The tick is still counted, using the `counting` value from before the command.
- R10: `load_en` writes `load_val` into `count_q` at the next edge. A tick in the same cycle is dropped, and the load never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle line-frequency strobe, synchronous to clk |
| cmd_valid | input | 1 | Processor I/O command strobe |
| cmd_pulse | input | 6 | Pulse field: bit 0 skip test, bit 2 clear/set-enable, bit 5 enable modifier |
| clear_all | input | 1 | Clear-all-flags command |
| load_en | input | 1 | Write strobe for the count word |
| load_val | input | 18 | Value written into the count word |
| skip | output | 1 | Skip request for the current command |
| clk_flag | output | 1 | Completion flag, also the status-word bit |
| counting | output | 1 | Enable state of the counter |
| count_q | output | 18 | Current count word |

## Verification
The assertions assume every input is sampled at a rising edge and holds a known 0 or 1 there. They also assume `tick` is treated as one event per cycle in which it is high, so a strobe held for two cycles counts twice.

The bench follows these assumptions:
- It changes inputs one time unit after a rising edge.
- It raises each strobe for exactly one cycle.
- It reads the registered outputs one unit after the edge that updates them.
- It reads `skip` in the middle of the cycle that presents the command.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int PULSE_W   = 6;
  localparam int TEST_BIT  = 0;
  localparam int CLEAR_BIT = 2;
  localparam int ON_BIT    = 5;

  typedef struct packed {
    logic test;
    logic clear;
    logic turn_on;
  } cmd_dec_t;
endpackage

// File: rtl/ltc_ctrl.sv
module ltc_ctrl
  import ltc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [PULSE_W-1:0] cmd_pulse,
  input  logic               flag,
  output cmd_dec_t           dec,
  output logic               enable,
  output logic               skip
);
  logic unused_pulse_bits;

  assign unused_pulse_bits = ^{cmd_pulse[1], cmd_pulse[3], cmd_pulse[4]};

  always_comb begin
    dec.test    = cmd_valid & cmd_pulse[TEST_BIT];
    dec.clear   = cmd_valid & cmd_pulse[CLEAR_BIT];
    dec.turn_on = cmd_pulse[ON_BIT];
  end

  assign skip = dec.test & flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable <= 1'b0;
    else if (dec.clear) enable <= dec.turn_on;
  end

  // R6: a clear command with the modifier bit turns counting on
  p_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_pulse[CLEAR_BIT] && cmd_pulse[ON_BIT]) |=> enable);
  // R6: a clear command without the modifier bit turns counting off
  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_pulse[CLEAR_BIT] && !cmd_pulse[ON_BIT]) |=> !enable);
  // R7/R8: with no clear command, the enable state holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_pulse[CLEAR_BIT]) |=> $stable(enable));
  // R5: no skip while the command strobe is low
  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !skip);
endmodule

// File: rtl/ltc_counter.sv
module ltc_counter #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic step;

  assign step = tick & enable & ~load_en;
  assign wrap = step & (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (step)    count <= count + 1'b1;
  end

  // R2: a counting tick advances the word by one
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !load_en) |=> (count == CNT_W'($past(count) + 1'b1)));
  // R2: without a counting tick or a load, the word holds
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !(tick && enable)) |=> $stable(count));
  // R10: a load takes the written value, even alongside a tick
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val)));
endmodule

// File: rtl/ltc_flag.sv
module ltc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic clr_cmd,
  input  logic clr_all,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (clr_cmd | clr_all) flag <= 1'b0;
    else if (wrap)              flag <= 1'b1;
  end

  // R3: a wrapping tick raises the flag when no clear is present
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr_cmd && !clr_all) |=> flag);
  // R4: the flag is sticky while no clear is present
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_cmd && !clr_all) |=> flag);
  // R4: only a wrap can set the flag
  p_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !wrap) |=> !flag);
  // R9: a clear wins over a wrap in the same cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd || clr_all) |=> !flag);
endmodule

// File: rtl/ltc_line_clock.sv
module ltc_line_clock
  import ltc_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_pulse,
  input  logic             clear_all,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             skip,
  output logic             clk_flag,
  output logic             counting,
  output logic [CNT_W-1:0] count_q
);
  cmd_dec_t dec;
  logic     wrap;

  ltc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_pulse (cmd_pulse),
    .flag      (clk_flag),
    .dec       (dec),
    .enable    (counting),
    .skip      (skip)
  );

  ltc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (counting),
    .load_en  (load_en),
    .load_val (load_val),
    .count    (count_q),
    .wrap     (wrap)
  );

  ltc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .clr_cmd (dec.clear),
    .clr_all (clear_all),
    .flag    (clk_flag)
  );

  // R1: everything is idle during reset
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!clk_flag && !counting && count_q == '0));
  // R10: a load never raises the flag
  p_load_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clk_flag) |=> !clk_flag);
endmodule

// File: tb/sim_ltc_line_clock.sv
module sim_ltc_line_clock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, cmd_valid, clear_all, load_en;
  logic [5:0]  cmd_pulse;
  logic [17:0] load_val;
  logic        skip, clk_flag, counting;
  logic [17:0] count_q;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ltc_line_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_pulse(cmd_pulse), .clear_all(clear_all), .load_en(load_en),
    .load_val(load_val), .skip(skip), .clk_flag(clk_flag),
    .counting(counting), .count_q(count_q)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        ld;
    logic [17:0] val;
    logic        tk;
    logic        cv;
    logic [5:0]  pl;
    logic        ca;
    logic        e_skip;
    logic [17:0] e_cnt;
    logic        e_flag;
    logic        e_en;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b0}, // R2 tick while off
    '{4'd6,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o44, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b1}, // R6 turn on
    '{4'd2,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00001, 1'b0, 1'b1}, // R2
    '{4'd2,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00002, 1'b0, 1'b1}, // R2
    '{4'd10, 1'b1, 18'h3FFFE, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h3FFFE, 1'b0, 1'b1}, // R10 load beats tick
    '{4'd4,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b1}, // R4 nonzero no flag
    '{4'd3,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00000, 1'b1, 1'b1}, // R3 wrap
    '{4'd5,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o01, 1'b0, 1'b1, 18'h00000, 1'b1, 1'b1}, // R5 skip
    '{4'd7,  1'b0, 18'h00000, 1'b0, 1'b0, 6'o04, 1'b0, 1'b0, 18'h00000, 1'b1, 1'b1}, // R7 no strobe
    '{4'd4,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00001, 1'b1, 1'b1}, // R4 sticky
    '{4'd7,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o40, 1'b0, 1'b0, 18'h00001, 1'b1, 1'b1}, // R7 bit5 alone
    '{4'd8,  1'b0, 18'h00000, 1'b0, 1'b0, 6'o00, 1'b1, 1'b0, 18'h00001, 1'b0, 1'b1}, // R8 clear all
    '{4'd5,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o01, 1'b0, 1'b0, 18'h00001, 1'b0, 1'b1}, // R5 no skip
    '{4'd10, 1'b1, 18'h3FFFF, 1'b0, 1'b0, 6'o00, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b1}, // R10 load
    '{4'd9,  1'b0, 18'h00000, 1'b1, 1'b1, 6'o44, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b1}, // R9 cmd vs wrap
    '{4'd6,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o04, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b0}, // R6 turn off
    '{4'd2,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b0}, // R2 off
    '{4'd10, 1'b1, 18'h3FFFF, 1'b0, 1'b0, 6'o00, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b0}, // R10
    '{4'd2,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b0}, // R2 no wrap when off
    '{4'd6,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o44, 1'b0, 1'b0, 18'h3FFFF, 1'b0, 1'b1}, // R6
    '{4'd3,  1'b0, 18'h00000, 1'b1, 1'b0, 6'o00, 1'b0, 1'b0, 18'h00000, 1'b1, 1'b1}, // R3
    '{4'd5,  1'b0, 18'h00000, 1'b0, 1'b1, 6'o05, 1'b0, 1'b1, 18'h00000, 1'b0, 1'b0}  // R5/R6 skip+clear
  };

  task automatic check(input string tag, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tick = 0; cmd_valid = 0; cmd_pulse = '0; clear_all = 0;
    load_en = 0; load_val = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("reset count", 1, 32'(count_q), 0);
    check("reset flag", 1, 32'(clk_flag), 0);
    check("reset enable", 1, 32'(counting), 0);
    rst_n = 1;
    step();

    for (int i = 0; i < NV; i++) begin
      load_en = VEC[i].ld; load_val = VEC[i].val; tick = VEC[i].tk;
      cmd_valid = VEC[i].cv; cmd_pulse = VEC[i].pl; clear_all = VEC[i].ca;
      #1;
      check($sformatf("vec %0d skip", i), int'(VEC[i].req), 32'(skip), 32'(VEC[i].e_skip));
      step();
      check($sformatf("vec %0d count", i), int'(VEC[i].req), 32'(count_q), 32'(VEC[i].e_cnt));
      check($sformatf("vec %0d flag", i), int'(VEC[i].req), 32'(clk_flag), 32'(VEC[i].e_flag));
      check($sformatf("vec %0d enable", i), int'(VEC[i].req), 32'(counting), 32'(VEC[i].e_en));
    end
    idle_inputs();

    // R9: clear_all meets a wrapping tick; the flag stays clear and the count wraps
    cmd_valid = 1; cmd_pulse = 6'o44; step(); idle_inputs();
    load_en = 1; load_val = 18'h3FFFF; step(); idle_inputs();
    tick = 1; clear_all = 1; step(); idle_inputs();
    check("clear_all vs wrap flag", 9, 32'(clk_flag), 0);
    check("clear_all vs wrap count", 9, 32'(count_q), 0);
    check("clear_all keeps enable", 8, 32'(counting), 1);

    // R9: an off command in the wrapping cycle still counts with the old enable
    load_en = 1; load_val = 18'h3FFFF; step(); idle_inputs();
    tick = 1; cmd_valid = 1; cmd_pulse = 6'o04; step(); idle_inputs();
    check("off vs wrap count", 9, 32'(count_q), 0);
    check("off vs wrap flag", 9, 32'(clk_flag), 0);
    check("off vs wrap enable", 6, 32'(counting), 0);

    // R10: a load that writes zero does not raise the flag
    load_en = 1; load_val = 18'h00000; step(); idle_inputs();
    check("load zero flag", 10, 32'(clk_flag), 0);

    // R1: reset in the middle of a run clears everything
    cmd_valid = 1; cmd_pulse = 6'o44; step(); idle_inputs();
    load_en = 1; load_val = 18'h3FFFF; step(); idle_inputs();
    tick = 1; step(); idle_inputs();
    check("pre-reset flag", 3, 32'(clk_flag), 1);
    rst_n = 0; #1;
    check("mid reset flag", 1, 32'(clk_flag), 0);
    check("mid reset enable", 1, 32'(counting), 0);
    check("mid reset count", 1, 32'(count_q), 0);
    step(); rst_n = 1; step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule